// File: doc/BRIEF.md
# Tagged-Record Identifier Extractor

This block scans a 128-byte configuration image that sits in a small byte-wide memory. It reads the image one byte at a time and follows a chain of variable-length records to locate a 64-bit world-wide identifier. Records come in two header formats. A one-byte header carries a short length. A three-byte header carries a 16-bit length. Inside one particular large record type the block runs a second, nested walk over subfields until it finds the subfield that holds the identifier.

A single `start` strobe launches a walk. The block then drives its memory read port, which returns data one cycle after the address. When the walk ends, `done` pulses and the outputs hold the identifier, the byte offset where it begins and a `found` flag. These outputs keep their values until the next accepted start. The block is intended to run once after reset so that the adapter's name is available to the rest of the chip.

Top module: `wwn_walker`

## Requirements
- R1: After reset, `done`, `found` and `rd_en` are 0, and `id` and `id_off` are 0.
- R2: A header byte with bit 7 = 0 is a short record: name = bits 6:3, total length = 1 + bits 2:0. A short record named 0xF (header bytes 0x78 to 0x7F) ends the walk, and no later record is examined.
- R3: A header byte with bit 7 = 1 is a long record: name = bits 6:0, total length = 3 + the 16-bit value in the next two bytes (low byte first). The walk resumes at the byte that follows the record.
- R4: Only a long record named 0x0D is searched. Identifier subfields inside long records with any other name are ignored.
- R5: If the byte at header offset + 3 of a 0x0D record is 0x3B, the record counts as 6 bytes long and no subfield search is done.
- R6: Subfields of a 0x0D record start at header offset + 3. A subfield's name is bits 5:0 of its first byte (so 0x7C also selects 0x3C). Its length is the 16-bit value in the next two bytes (low byte first), and the subfield walk advances by length + 3. Once the subfield walk reaches or passes the end of the record, the record walk resumes at the record's end.
- R7: A subfield named 0x3C holds an 8-byte identifier that starts 3 bytes after the subfield header. The first byte read lands in `id[63:56]`. `id_off` reports the starting offset and `found` goes to 1.
- R8: The walk continues after an identifier is found, and the last identifier subfield met is the one reported. Each accepted start clears `id`, `id_off` and `found` to 0.
- R9: No read is issued at an address of 128 or above. The walk ends with `done` in any of these cases: the next byte needed lies at offset 128 or beyond; a 0x0D record or any subfield extends past offset 127; or an identifier's 8 bytes would pass offset 127. If nothing was found, `found` stays 0 and `id_off` stays 0.
- R10: `done` is high for exactly one cycle, and no read is issued in that cycle. A `start` pulse that arrives during a walk is ignored.
- R11: Reads are issued with `rd_en` and `rd_addr`, and the byte is taken from `rd_data` in the following cycle. `rd_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a walk when the block is idle |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 7 | Memory byte address |
| rd_data | input | 8 | Memory byte, valid the cycle after the request |
| id | output | 64 | Extracted identifier, first byte in the top bits |
| id_off | output | 7 | Offset of the identifier's first byte, 0 if none |
| found | output | 1 | An identifier was located |
| done | output | 1 | One-cycle walk-complete pulse |

## Verification
Two cases put separate functions in the same cycle. In the first, the cycle that takes the eighth identifier byte both commits the identifier and finds that the walk has reached offset 128, so the result update and the `done` pulse land together. An image whose 0x0D record ends exactly at the image boundary provokes this, and the bench judges it by reading `id`, `id_off` and `found` in the `done` cycle. In the second, a `start` arrives while a walk is running. The bench provokes this by pulsing `start` part-way through a walk and judges it by requiring the same start-to-done latency and the same result as an undisturbed run.

// File: rtl/wwn_walk_pkg.sv
package wwn_walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_TAKE = 2'd2
    } walk_st_e;

    // which byte of the image the pending read returns
    typedef enum logic [2:0] {
        PH_HDR   = 3'd0,
        PH_RLO   = 3'd1,
        PH_RHI   = 3'd2,
        PH_BODY0 = 3'd3,
        PH_SHDR  = 3'd4,
        PH_SLO   = 3'd5,
        PH_SHI   = 3'd6,
        PH_ID    = 3'd7
    } walk_ph_e;

    localparam logic [3:0] END_NAME   = 4'hF;
    localparam logic [6:0] SEARCH_REC = 7'h0D;
    localparam logic [7:0] SKIP_BYTE  = 8'h3B;
    localparam logic [5:0] ID_SUB     = 6'h3C;
    localparam int         LEN_W      = 16;

endpackage

// File: rtl/wwn_hdr_decode.sv
module wwn_hdr_decode
    import wwn_walk_pkg::*;
(
    input  logic [7:0] hdr_byte,
    output logic       is_large,
    output logic       is_end,
    output logic [3:0] small_len,
    output logic [6:0] large_name,
    output logic [5:0] sub_name
);

    always_comb begin
        is_large   = hdr_byte[7];
        large_name = hdr_byte[6:0];
        sub_name   = hdr_byte[5:0];
        small_len  = 4'd1 + {1'b0, hdr_byte[2:0]};
        is_end     = !hdr_byte[7] && (hdr_byte[6:3] == END_NAME);
    end

endmodule

// File: rtl/wwn_span_add.sv
module wwn_span_add
    import wwn_walk_pkg::*;
#(
    parameter int SPAN_W    = 18,
    parameter int IMG_BYTES = 128
) (
    input  logic [SPAN_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic [SPAN_W-1:0] sum,
    output logic              past_end
);

    localparam logic [SPAN_W-1:0] LIMIT = SPAN_W'(IMG_BYTES);

    always_comb begin
        sum      = base + SPAN_W'(3) + SPAN_W'(len);
        past_end = sum > LIMIT;
    end

endmodule

// File: rtl/wwn_id_shift.sv
module wwn_id_shift #(
    parameter int LANES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [LANES*8-1:0] dout
);

    localparam int W = LANES * 8;

    logic [W-1:0] stage_d, stage_q;
    logic [W-1:0] shifted;

    if (LANES == 1) begin : g_single
        assign shifted = din;
    end else begin : g_chain
        assign shifted = {stage_q[W-9:0], din};
    end

    always_comb begin
        stage_d = stage_q;
        if (clr) begin
            stage_d = '0;
        end else if (shift) begin
            stage_d = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q;

endmodule

// File: rtl/wwn_walker.sv
module wwn_walker
    import wwn_walk_pkg::*;
#(
    parameter int IMG_BYTES = 128,
    parameter int ID_BYTES  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         rd_en,
    output logic [$clog2(IMG_BYTES)-1:0] rd_addr,
    input  logic [7:0]                   rd_data,
    output logic [ID_BYTES*8-1:0]        id,
    output logic [$clog2(IMG_BYTES)-1:0] id_off,
    output logic                         found,
    output logic                         done
);

    localparam int ADDR_W = $clog2(IMG_BYTES);
    localparam int ID_W   = ID_BYTES * 8;
    localparam int CNT_W  = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam int SPAN_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
    localparam logic [SPAN_W-1:0] LIMIT = SPAN_W'(IMG_BYTES);
    localparam logic [SPAN_W-1:0] ID_SPAN = SPAN_W'(3 + ID_BYTES);

    typedef struct packed {
        walk_st_e          st;
        walk_ph_e          ph;
        logic [SPAN_W-1:0] ptr;
        logic [SPAN_W-1:0] rec_base;
        logic [SPAN_W-1:0] rec_end;
        logic [SPAN_W-1:0] sub_base;
        logic [SPAN_W-1:0] sub_next;
        logic [6:0]        rec_name;
        logic [5:0]        sub_name;
        logic [7:0]        len_lo;
        logic [CNT_W-1:0]  cnt;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] off;
        logic              found;
        logic              done;
    } walk_s;

    walk_s q, n;

    // header field decode of the byte returned this cycle
    logic       hd_large, hd_end;
    logic [3:0] hd_small_len;
    logic [6:0] hd_large_name;
    logic [5:0] hd_sub_name;

    wwn_hdr_decode u_dec (
        .hdr_byte  (rd_data),
        .is_large  (hd_large),
        .is_end    (hd_end),
        .small_len (hd_small_len),
        .large_name(hd_large_name),
        .sub_name  (hd_sub_name)
    );

    // one adder shared by record and subfield length arithmetic
    logic [SPAN_W-1:0] span_base, span_sum;
    logic              span_over;

    assign span_base = (q.ph == PH_RHI) ? q.rec_base : q.sub_base;

    wwn_span_add #(.SPAN_W(SPAN_W), .IMG_BYTES(IMG_BYTES)) u_span (
        .base    (span_base),
        .len     ({rd_data, q.len_lo}),
        .sum     (span_sum),
        .past_end(span_over)
    );

    // staging of identifier bytes until all are in
    logic              shift_en, stage_clr;
    logic [ID_W-9:0]   stage;

    wwn_id_shift #(.LANES(ID_BYTES - 1)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (stage_clr),
        .shift(shift_en),
        .din  (rd_data),
        .dout (stage)
    );

    // next read request and walk termination
    logic              go_rd, go_fin;
    logic [SPAN_W-1:0] go_addr;
    walk_ph_e          go_ph;
    logic [SPAN_W-1:0] sub_tgt;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        go_rd     = 1'b0;
        go_fin    = 1'b0;
        go_addr   = '0;
        go_ph     = PH_HDR;
        shift_en  = 1'b0;
        stage_clr = 1'b0;
        sub_tgt   = (q.ph == PH_ID) ? q.sub_next : span_sum;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.found   = 1'b0;
                    n.off     = '0;
                    n.id      = '0;
                    stage_clr = 1'b1;
                    go_rd     = 1'b1;
                    go_addr   = '0;
                    go_ph     = PH_HDR;
                end
            end
            ST_RD: begin
                n.st = ST_TAKE;
            end
            ST_TAKE: begin
                case (q.ph)
                    PH_HDR: begin
                        if (!hd_large) begin
                            if (hd_end) begin
                                go_fin = 1'b1;
                            end else begin
                                go_rd   = 1'b1;
                                go_addr = q.ptr + SPAN_W'(hd_small_len);
                                go_ph   = PH_HDR;
                            end
                        end else begin
                            n.rec_name = hd_large_name;
                            n.rec_base = q.ptr;
                            go_rd      = 1'b1;
                            go_addr    = q.ptr + SPAN_W'(1);
                            go_ph      = PH_RLO;
                        end
                    end
                    PH_RLO: begin
                        n.len_lo = rd_data;
                        go_rd    = 1'b1;
                        go_addr  = q.rec_base + SPAN_W'(2);
                        go_ph    = PH_RHI;
                    end
                    PH_RHI: begin
                        n.rec_end = span_sum;
                        go_rd     = 1'b1;
                        if (q.rec_name == SEARCH_REC) begin
                            go_addr = q.rec_base + SPAN_W'(3);
                            go_ph   = PH_BODY0;
                        end else begin
                            go_addr = span_sum;
                            go_ph   = PH_HDR;
                        end
                    end
                    PH_BODY0, PH_SHDR: begin
                        if (q.ph == PH_BODY0 && rd_data == SKIP_BYTE) begin
                            go_rd   = 1'b1;
                            go_addr = q.rec_base + SPAN_W'(6);
                            go_ph   = PH_HDR;
                        end else if (q.ph == PH_BODY0 && q.rec_end > LIMIT) begin
                            go_fin = 1'b1;
                        end else if (q.ptr >= q.rec_end) begin
                            go_rd   = 1'b1;
                            go_addr = q.rec_end;
                            go_ph   = PH_HDR;
                        end else begin
                            n.sub_base = q.ptr;
                            n.sub_name = hd_sub_name;
                            go_rd      = 1'b1;
                            go_addr    = q.ptr + SPAN_W'(1);
                            go_ph      = PH_SLO;
                        end
                    end
                    PH_SLO: begin
                        n.len_lo = rd_data;
                        go_rd    = 1'b1;
                        go_addr  = q.sub_base + SPAN_W'(2);
                        go_ph    = PH_SHI;
                    end
                    PH_SHI: begin
                        if (span_over) begin
                            go_fin = 1'b1;
                        end else if (q.sub_name == ID_SUB) begin
                            if (q.sub_base + ID_SPAN > LIMIT) begin
                                go_fin = 1'b1;
                            end else begin
                                n.sub_next = span_sum;
                                n.cnt      = '0;
                                go_rd      = 1'b1;
                                go_addr    = q.sub_base + SPAN_W'(3);
                                go_ph      = PH_ID;
                            end
                        end else begin
                            go_rd = 1'b1;
                            if (sub_tgt >= q.rec_end) begin
                                go_addr = q.rec_end;
                                go_ph   = PH_HDR;
                            end else begin
                                go_addr = sub_tgt;
                                go_ph   = PH_SHDR;
                            end
                        end
                    end
                    PH_ID: begin
                        shift_en = 1'b1;
                        go_rd    = 1'b1;
                        if (q.cnt == CNT_W'(ID_BYTES - 1)) begin
                            n.id    = {stage, rd_data};
                            n.off   = ADDR_W'(q.sub_base + SPAN_W'(3));
                            n.found = 1'b1;
                            if (sub_tgt >= q.rec_end) begin
                                go_addr = q.rec_end;
                                go_ph   = PH_HDR;
                            end else begin
                                go_addr = sub_tgt;
                                go_ph   = PH_SHDR;
                            end
                        end else begin
                            n.cnt   = q.cnt + CNT_W'(1);
                            go_addr = q.ptr + SPAN_W'(1);
                            go_ph   = PH_ID;
                        end
                    end
                    default: go_fin = 1'b1;
                endcase
            end
            default: n.st = ST_IDLE;
        endcase

        if (go_fin || (go_rd && go_addr >= LIMIT)) begin
            n.st   = ST_IDLE;
            n.done = 1'b1;
        end else if (go_rd) begin
            n.st  = ST_RD;
            n.ptr = go_addr;
            n.ph  = go_ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    logic [SPAN_W-1:0] walk_ptr;
    assign walk_ptr = q.ptr;

    assign rd_en   = (q.st == ST_RD);
    assign rd_addr = q.ptr[ADDR_W-1:0];
    assign id      = q.id;
    assign id_off  = q.off;
    assign found   = q.found;
    assign done    = q.done;

endmodule

// File: rtl/wwn_walker_chk.sv
module wwn_walker_chk #(
    parameter int IMG_BYTES = 128,
    parameter int ADDR_W    = 7,
    parameter int SPAN_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_en,
    input logic              done,
    input logic              found,
    input logic [ADDR_W-1:0] id_off,
    input logic [SPAN_W-1:0] ptr
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

    a_r9_read_inside_image: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (ptr < SPAN_W'(IMG_BYTES)));

    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    a_r7_found_has_offset: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (id_off != '0));

    a_r8_found_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> found);

endmodule

bind wwn_walker wwn_walker_chk #(
    .IMG_BYTES(IMG_BYTES),
    .ADDR_W   (ADDR_W),
    .SPAN_W   (SPAN_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .rd_en (rd_en),
    .done  (done),
    .found (found),
    .id_off(id_off),
    .ptr   (walk_ptr)
);

// File: tb/wwn_walker_bench.sv
module wwn_walker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IMG        = 128;
    localparam int PW         = 28;
    localparam int NV         = 11;
    localparam logic [63:0] ID_A = 64'h1122334455667788;
    localparam logic [63:0] ID_B = 64'hA1A2A3A4A5A6A7A8;

    typedef struct packed {
        logic [PW*8-1:0] img;
        logic [7:0]      n;
        logic [7:0]      fill;
        logic [3:0]      req;
        logic            found;
        logic [6:0]      off;
        logic [63:0]     id;
    } vec_t;

    // bytes are right-aligned: the first image byte is the leftmost of n
    localparam vec_t VECS [NV] = '{
        // R7 basic identifier at offset 6
        '{224'h8D0B003C0800_1122334455667788_78, 8'd15, 8'h78, 4'd7, 1'b1, 7'd6, ID_A},
        // R2 short records 0x13 (len 4) and 0x01 (len 2) skipped first
        '{224'h13AABBCC01DD_8D0B003C0800_1122334455667788_78, 8'd21, 8'h78, 4'd2, 1'b1, 7'd12, ID_A},
        // R4 same layout inside record 0x0E is ignored; R8 clears prior result
        '{224'h8E0B003C0800_1122334455667788_78, 8'd15, 8'h78, 4'd4, 1'b0, 7'd0, 64'h0},
        // R3 long record 0x10 with length 5 is stepped over
        '{224'h9005003C08009999_8D0B003C0800_1122334455667788_78, 8'd23, 8'h78, 4'd3, 1'b1, 7'd14, ID_A},
        // R5 first body byte 0x3B: advance 6, not 35
        '{224'h8D20003B0000_8D0B003C0800_1122334455667788_78, 8'd21, 8'h78, 4'd5, 1'b1, 7'd12, ID_A},
        // R6 second subfield, name byte 0x7C masked to 0x3C
        '{224'h8D1000010200AABB_7C0800_1122334455667788_78, 8'd20, 8'h78, 4'd6, 1'b1, 7'd11, ID_A},
        // R8 two identifier subfields, the later one wins
        '{224'h8D16003C0800_1122334455667788_3C0800_A1A2A3A4A5A6A7A8_78, 8'd26, 8'h78, 4'd8, 1'b1, 7'd17, ID_B},
        // R9 no end marker: walk runs to offset 128 and keeps result
        '{224'h8D0B003C0800_1122334455667788, 8'd14, 8'h00, 4'd9, 1'b1, 7'd6, ID_A},
        // R9 long record length 259 overruns the image
        '{224'h900001, 8'd3, 8'h78, 4'd9, 1'b0, 7'd0, 64'h0},
        // R6 subfield overruns its record: walk resumes at record end
        '{224'h8D0400010500EE_8D0B003C0800_1122334455667788_78, 8'd22, 8'h78, 4'd6, 1'b1, 7'd13, ID_A},
        // R2 end marker 0x7F stops before the searchable record
        '{224'h7F8D0B003C0800_1122334455667788, 8'd15, 8'h78, 4'd2, 1'b0, 7'd0, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [63:0] id;
    logic [6:0]  id_off;
    logic        found;
    logic        done;

    logic [7:0]  mem [IMG];
    int          n_checks = 0;
    int          n_fail = 0;
    int          b2b = 0;
    int          rd_at_done = 0;
    logic        rd_en_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always @(negedge clk) begin
        if (rd_en && rd_en_prev) b2b++;
        if (rd_en && done) rd_at_done++;
        rd_en_prev <= rd_en;
    end

    wwn_walker u_wwn_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .id     (id),
        .id_off (id_off),
        .found  (found),
        .done   (done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_fill(input logic [7:0] f);
        for (int k = 0; k < IMG; k++) mem[k] = f;
    endtask

    task automatic run_walk(input int extra_at, output int cycles);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 5000) begin
            start = (cycles == extra_at);
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: walk never finished, actual done 0 expected 1");
        end
    endtask

    task automatic check_pulse_end();
        @(negedge clk);
        check("R10 done one cycle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        int c_ref;
        load_fill(8'h78);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {63'h0, done}, 64'h0);
        check("R1 found", {63'h0, found}, 64'h0);
        check("R1 rd_en", {63'h0, rd_en}, 64'h0);
        check("R1 id", id, 64'h0);
        check("R1 id_off", {57'h0, id_off}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            load_fill(VECS[v].fill);
            for (int k = 0; k < int'(VECS[v].n); k++)
                mem[k] = VECS[v].img[(int'(VECS[v].n) - 1 - k) * 8 +: 8];
            run_walk(-1, cyc);
            check({tag, " found"}, {63'h0, found}, {63'h0, VECS[v].found});
            check({tag, " offset"}, {57'h0, id_off}, {57'h0, VECS[v].off});
            check({tag, " id"}, id, VECS[v].id);
            check_pulse_end();
        end

        // R9 record ends exactly at offset 128; id commit and done coincide
        load_fill(8'h00);
        mem[114] = 8'h8D; mem[115] = 8'h0B; mem[116] = 8'h00;
        mem[117] = 8'h3C; mem[118] = 8'h08; mem[119] = 8'h00;
        for (int k = 0; k < 8; k++) mem[120 + k] = ID_B[63 - 8 * k -: 8];
        run_walk(-1, cyc);
        check("R9 edge found", {63'h0, found}, 64'h1);
        check("R9 edge offset", {57'h0, id_off}, 64'd120);
        check("R9 edge id", id, ID_B);

        // R9 searchable record overruns the image by two bytes
        load_fill(8'h00);
        mem[116] = 8'h8D; mem[117] = 8'h0B; mem[118] = 8'h00;
        mem[119] = 8'h3C; mem[120] = 8'h08; mem[121] = 8'h00;
        run_walk(-1, cyc);
        check("R9 overrun found", {63'h0, found}, 64'h0);
        check("R9 overrun offset", {57'h0, id_off}, 64'h0);

        // R9 long header in the last byte
        load_fill(8'h00);
        mem[127] = 8'h8D;
        run_walk(-1, cyc);
        check("R9 last-byte header found", {63'h0, found}, 64'h0);

        // R10 start during a walk is ignored
        load_fill(8'h78);
        for (int k = 0; k < int'(VECS[6].n); k++)
            mem[k] = VECS[6].img[(int'(VECS[6].n) - 1 - k) * 8 +: 8];
        run_walk(-1, c_ref);
        run_walk(8, cyc);
        check("R10 busy start latency", 64'(cyc), 64'(c_ref));
        check("R10 busy start id", id, ID_B);
        check_pulse_end();

        // R11 read spacing and no read in the done cycle
        check("R11 back-to-back reads", 64'(b2b), 64'h0);
        check("R10 read during done", 64'(rd_at_done), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule